// File: doc/BRIEF.md
# Post-Demodulation Low-Pass Filter with Zero-Threshold Slicer

This block sits behind a frequency discriminator in an FSK receiver. Each cycle that its input strobe is high, it takes one signed 12-bit discriminator sample. It passes the sample through two cascaded first-order smoothing sections, which together form a second-order low-pass response. It then gives out both the smoothed sample and a hard data bit. The discriminator output is always centred on zero, so the bit decision compares the filtered value against a fixed zero threshold. Nothing adapts to the data pattern, and long runs of one symbol cannot drag the decision point.

The cutoff is set by a 10-bit unsigned coefficient, approximately 2^11·π·Fcutoff divided by the demodulator clock. Each section multiplies its error by this coefficient and scales the product by 2^-10. As a worked case, a 200 kbit/s link wants a cutoff near 0.75 times the data rate. With an 11.0592 MHz demodulator clock, that cutoff gives a coefficient of 87. The coefficient may be rewritten between any two samples. Each sample carries its own coefficient value through both sections.

Top module: `pdlpf_slicer`

## Requirements
- R1: A synchronous reset clears both filter sections to zero. In the cycle after reset, out_valid is 0, out_sample is 0 and out_bit is 1.
- R2: Each input cycle with in_valid high produces exactly one out_valid pulse, two clock cycles later. When in_valid is low, no pulse is produced.
- R3: Each section holds a 22-bit signed state with 10 fractional bits. The section input is the sample multiplied by 1024. On each sample, the section updates as y ← sat(y + floor(k·(x − y)/1024)).
- R4: The second section is fed by the first section's new state. It uses the same coefficient as the sample that produced that state.
- R5: out_sample is floor(y2/1024) of the second-section state, as a 12-bit signed value.
- R6: out_bit is 1 when the second-section state is zero or positive, and 0 when it is negative.
- R7: A coefficient of 0 freezes both section states, so out_sample and out_bit repeat their previous values.
- R8: A coefficient change between consecutive samples applies to the next sample, with no reset and no settling cycles.
- R9: Each update moves a section's state toward its input without overshooting it. A constant input settles to that value, so the state never leaves the input range.
- R10: A long run of constant positive input gives out_bit 1 on every output. A long run of constant negative input gives 0 once the filter has crossed zero.
- R11: Between output pulses, out_sample and out_bit hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Demodulator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Discriminator sample strobe |
| in_sample | input | 12 | Signed discriminator sample |
| in_coef | input | 10 | Unsigned bandwidth coefficient |
| out_valid | output | 1 | Strobe for out_sample and out_bit |
| out_sample | output | 12 | Filtered signed sample |
| out_bit | output | 1 | Sliced data bit (1 when the filtered value is at least 0) |

## Verification
A wrong section state does not stay hidden. It shows up at out_sample on the second cycle after the sample that created it, at the latest. It then keeps showing in every later output, because both sections feed back on themselves. Only an error in the 10 fractional bits can stay below one output LSB; it surfaces after the next few samples at a moderate coefficient. A wrong coefficient path or a wrong stage ordering shows up as a different settling curve within one pulse. A wrong slicer shows up as out_bit disagreeing with the sign of the expected sample.

// File: rtl/pdlpf_pkg.sv
package pdlpf_pkg;
    localparam int DEF_IN_W   = 12;
    localparam int DEF_COEF_W = 10;
    localparam int DEF_FRAC_W = 10;
    localparam int DEF_SHIFT  = 10;
    localparam int DEF_STAGES = 2;
endpackage

// File: rtl/pdlpf_section.sv
module pdlpf_section #(
    parameter int ST_W   = 22,
    parameter int COEF_W = 10,
    parameter int SHIFT  = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [ST_W-1:0]   in_x,
    input  logic [COEF_W-1:0]        in_k,
    output logic                     out_valid,
    output logic signed [ST_W-1:0]   out_y,
    output logic [COEF_W-1:0]        out_k
);
    localparam int D_W = ST_W + 1;
    localparam int P_W = D_W + COEF_W + 1;
    localparam logic signed [P_W-1:0] MAX_P = {{(P_W-ST_W+1){1'b0}}, {(ST_W-1){1'b1}}};
    localparam logic signed [P_W-1:0] MIN_P = {{(P_W-ST_W+1){1'b1}}, {(ST_W-1){1'b0}}};

    typedef struct packed {
        logic                   vld;
        logic signed [ST_W-1:0] y;
        logic [COEF_W-1:0]      k;
    } sec_st_t;

    sec_st_t st_d, st_q;

    logic signed [D_W-1:0] diff_w;
    logic signed [P_W-1:0] coef_w;
    logic signed [P_W-1:0] prod_w;
    logic signed [P_W-1:0] step_w;
    logic signed [P_W-1:0] sum_w;
    logic signed [ST_W-1:0] sat_w;

    always_comb begin
        diff_w = D_W'(in_x) - D_W'(st_q.y);
        coef_w = P_W'($signed({1'b0, in_k}));
        prod_w = coef_w * P_W'(diff_w);
        step_w = prod_w >>> SHIFT;
        sum_w  = P_W'(st_q.y) + step_w;
        if (sum_w > MAX_P) begin
            sat_w = MAX_P[ST_W-1:0];
        end else if (sum_w < MIN_P) begin
            sat_w = MIN_P[ST_W-1:0];
        end else begin
            sat_w = sum_w[ST_W-1:0];
        end

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.y = sat_w;
            st_d.k = in_k;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_y     = st_q.y;
    assign out_k     = st_q.k;

    // R9
    toward_up_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_x >= st_q.y)) |=> ((st_q.y >= $past(st_q.y)) && (st_q.y <= $past(in_x))));

    // R9
    toward_down_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_x < st_q.y)) |=> ((st_q.y <= $past(st_q.y)) && (st_q.y >= $past(in_x))));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_k == '0)) |=> $stable(st_q.y));
endmodule

// File: rtl/pdlpf_slicer_stage.sv
module pdlpf_slicer_stage #(
    parameter int ST_W   = 22,
    parameter int IN_W   = 12,
    parameter int FRAC_W = 10
) (
    input  logic signed [ST_W-1:0] in_y,
    output logic signed [IN_W-1:0] out_sample,
    output logic                   out_bit
);
    logic signed [ST_W-1:0] shifted_w;

    always_comb begin
        shifted_w  = in_y >>> FRAC_W;
        out_sample = shifted_w[IN_W-1:0];
        out_bit    = (in_y >= 0);
    end
endmodule

// File: rtl/pdlpf_slicer.sv
module pdlpf_slicer
    import pdlpf_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int SHIFT  = DEF_SHIFT,
    parameter int STAGES = DEF_STAGES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic [COEF_W-1:0]      in_coef,
    output logic                   out_valid,
    output logic signed [IN_W-1:0] out_sample,
    output logic                   out_bit
);
    localparam int ST_W = IN_W + FRAC_W;

    logic                   vld_c [0:STAGES];
    logic signed [ST_W-1:0] y_c   [0:STAGES];
    logic [COEF_W-1:0]      k_c   [0:STAGES];

    assign vld_c[0] = in_valid;
    assign y_c[0]   = {in_sample, {FRAC_W{1'b0}}};
    assign k_c[0]   = in_coef;

    for (genvar g = 0; g < STAGES; g++) begin : g_sec
        pdlpf_section #(
            .ST_W   (ST_W),
            .COEF_W (COEF_W),
            .SHIFT  (SHIFT)
        ) u_sec (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (vld_c[g]),
            .in_x      (y_c[g]),
            .in_k      (k_c[g]),
            .out_valid (vld_c[g+1]),
            .out_y     (y_c[g+1]),
            .out_k     (k_c[g+1])
        );
    end

    pdlpf_slicer_stage #(
        .ST_W   (ST_W),
        .IN_W   (IN_W),
        .FRAC_W (FRAC_W)
    ) u_slice (
        .in_y       (y_c[STAGES]),
        .out_sample (out_sample),
        .out_bit    (out_bit)
    );

    assign out_valid = vld_c[STAGES];

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R4
    coef_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 (k_c[STAGES] == $past(in_coef, 2)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_c[STAGES-1] |=> ($stable(out_sample) && $stable(out_bit) && !out_valid));
endmodule

// File: tb/pdlpf_slicer_tb.sv
module pdlpf_slicer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic [9:0] in_coef = '0;
    logic out_valid;
    logic signed [11:0] out_sample;
    logic out_bit;

    always #5 clk = ~clk;

    pdlpf_slicer u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_coef    (in_coef),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_bit    (out_bit)
    );

    int vectors = 0;
    int misses = 0;
    int cyc = 0;
    bit done = 0;
    string req = "R1";
    longint m1 = 0, m2 = 0, last_y = 0;
    int due_q[$];
    longint yv_q[$];
    logic [15:0] lfsr = 16'hACE1;

    function automatic longint sec_upd(longint y, longint x, longint k);
        longint p, r;
        p = k * (x - y);
        r = y + (p >>> 10);
        if (r > 2097151) r = 2097151;
        if (r < -2097152) r = -2097152;
        return r;
    endfunction

    task automatic check_now();
        logic exp_v;
        longint e_s;
        logic exp_b;
        exp_v = 1'b0;
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            exp_v = 1'b1;
            last_y = yv_q[0];
            void'(due_q.pop_front());
            void'(yv_q.pop_front());
        end
        e_s = last_y >>> 10;
        exp_b = (last_y >= 0);
        vectors++;
        if (out_valid !== exp_v || out_sample !== 12'(e_s) || out_bit !== exp_b) begin
            misses++;
            $display("FAIL %s cyc %0d: valid/sample/bit = %0b/%0d/%0b expected %0b/%0d/%0b",
                     req, cyc, out_valid, out_sample, out_bit, exp_v, e_s, exp_b);
        end
    endtask

    task automatic step(input bit r, input bit v, input int s, input int k);
        @(negedge clk);
        check_now();
        rst = r;
        in_valid = v;
        in_sample = 12'(s);
        in_coef = 10'(k);
        if (r) begin
            due_q.delete();
            yv_q.delete();
            m1 = 0;
            m2 = 0;
            last_y = 0;
        end else if (v) begin
            m1 = sec_upd(m1, longint'(s) * 1024, k);
            m2 = sec_upd(m2, m1, k);
            due_q.push_back(cyc + 2);
            yv_q.push_back(m2);
        end
        cyc++;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: reset state checked from the first compared cycle
        @(negedge clk);
        rst = 1'b1;
        cyc = 0;
        req = "R1";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R3 R4 R5 R9 R10: positive DC step, k = 87, continuous strobe
        req = "R3_R4_R5_R9_R10_pos";
        for (int i = 0; i < 200; i++) step(0, 1, 1000, 87);
        step(0, 0, 0, 87);
        step(0, 0, 0, 87);

        // R2 R6 R11: negative step with gaps between samples
        req = "R2_R6_R11_gaps";
        for (int i = 0; i < 240; i++) step(0, (i % 3) == 0, -1500, 87);

        // R10: long negative run keeps 0 decisions
        req = "R10_neg_run";
        for (int i = 0; i < 150; i++) step(0, 1, -700, 200);

        // R7: zero coefficient freezes state against changing input
        req = "R7_freeze";
        for (int i = 0; i < 40; i++) step(0, 1, (i * 97) % 2048, 0);

        // R8: coefficient changes every sample, pseudo-random input
        req = "R8_coef_change";
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(0, lfsr[0] | lfsr[5], int'($signed(lfsr[11:0])),
                 (i % 2 == 0) ? 1023 : int'(lfsr[15:6]));
        end

        // R3 R9: full-scale swings at largest coefficient
        req = "R3_R9_fullscale";
        for (int i = 0; i < 60; i++) step(0, 1, ((i / 5) % 2 == 0) ? 2047 : -2048, 1023);

        // R6: small values around zero, slicer boundary
        req = "R6_zero_edge";
        for (int i = 0; i < 60; i++) step(0, 1, (i % 4) - 2, 512);

        // R1: mid-run reset clears state
        req = "R1_midreset";
        step(1, 1, 500, 300);
        step(1, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 1, 300, 300);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 300);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule